// File: doc/BRIEF.md
# Two-Tier Interrupt Status Controller

This block gathers single-cycle event pulses from a touch-sensing front end, its sample FIFO, an analog converter and a general-purpose pin bank, and drives one interrupt line toward a host. Each event source has one bit in an 8-bit latched status vector. The converter and pin-bank events arrive already merged from their own per-channel status registers, which sit below this block and form the second tier. A status bit latches whenever its event fires, whatever the enables hold. The host finds the cause by reading the status vector and removes it by writing ones to the bits it has handled.

An 8-bit enable vector selects which latched bits may reach the output. A control register sets three things: a global gate, the signalling style (a held level, or a one-cycle pulse for each newly enabled event) and the output polarity. The output stage is a small state machine with three states. `IRQ_IDLE` means no request is active. `IRQ_LEVEL` holds the request while any enabled bit stays set. `IRQ_PULSE` lasts one cycle for each fresh enabled event. The transitions are: IDLE to LEVEL when level mode has a pending enabled bit; IDLE to PULSE when pulse mode sees a fresh enabled bit; LEVEL to IDLE when the gate closes, the pending bits clear or the mode changes to pulse; PULSE to PULSE when another fresh bit follows at once; PULSE to IDLE otherwise.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x10, the control and enable registers read 0x00, and `irq_out` is high, which is the inactive level for the active-low reset polarity.
- R2: An event pulse on `evt_in[i]` sets status bit i on the next clock edge, whether or not its enable bit is set. The bit layout is: bit0 touch, bit1 FIFO threshold, bit2 FIFO overflow, bit3 FIFO full, bit4 FIFO empty, bit6 converter (merged), bit7 pin bank (merged). Bit 5 is reserved: it never sets and always reads 0.
- R3: A write to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: The control register has the global enable in bit0, the type in bit1 (0 = level, 1 = pulse) and the polarity in bit2 (1 = active-high). Bits 7:3 read 0 whatever is written to them.
- R6: When the global enable is 1 and some status bit is set whose enable bit is also set, the output becomes active two clock edges after the event is sampled. Set status bits that are not enabled do not activate the output.
- R7: In level mode the output stays active until no enabled status bit remains set. It goes inactive one edge after the last enabled bit clears.
- R8: In pulse mode the output is active for exactly one cycle each time an enabled status bit goes from clear to set. A bit that stays set, or that sees a repeated event while already set, gives no further pulse.
- R9: Polarity applies combinationally. With polarity 1 the active output is 1 and the inactive output is 0; with polarity 0 the levels are swapped.
- R10: While the global enable is 0 the output is inactive one edge later, whatever the status and enable bits hold.
- R11: The register map is: address 0 = control, 1 = enable, 2 = status. Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 8 | Single-cycle event pulses, one per status bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Host interrupt line |

## Verification
The bench builds the block with its default parameters: an 8-bit status vector, a 2-bit address, a reset value of 0x10 and an implemented-bit mask that excludes bit 5. These values make the real bit layout, the reserved bit and the unused address all reachable. At these values every status bit can be driven at once, so the bench can check together that the reserved bit stays clear and that an event wins over a clear in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned CTRL_GEN_BIT  = 0;
    localparam int unsigned CTRL_TYPE_BIT = 1;
    localparam int unsigned CTRL_POL_BIT  = 2;
    localparam int unsigned CTRL_FIELDS   = 3;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_ENABLE = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_LEVEL = 2'd1,
        IRQ_PULSE = 2'd2
    } irq_state_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned W         = 8,
    parameter logic [W-1:0] RST_VAL  = 8'h10,
    parameter logic [W-1:0] IMPL_MSK = 8'hDF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_in,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] status_q
);

    logic [W-1:0] clr_vec;
    logic [W-1:0] evt_vec;
    logic [W-1:0] status_n;

    always_comb begin
        clr_vec  = clr_we ? clr_data : '0;
        evt_vec  = evt_in & IMPL_MSK;
        // a new event takes priority over a clear in the same cycle
        status_n = ((status_q & ~clr_vec) | evt_vec) & IMPL_MSK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= RST_VAL & IMPL_MSK;
        else        status_q <= status_n;
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_in & IMPL_MSK) != '0) |=>
        ((status_q & $past(evt_in & IMPL_MSK)) == $past(evt_in & IMPL_MSK)));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_in)) == '0));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~IMPL_MSK) == '0));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(clr_data & ~evt_in)) == '0));

    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_data & evt_in & IMPL_MSK) != '0)) |=>
        ((status_q & $past(clr_data & evt_in & IMPL_MSK)) ==
         $past(clr_data & evt_in & IMPL_MSK)));

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] en_q,
    output logic         glb_en,
    output logic         pulse_mode,
    output logic         act_high
);

    localparam logic [W-1:0] CTRL_MSK = W'((1 << CTRL_FIELDS) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            en_q   <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= wdata & CTRL_MSK;
            if (en_we)   en_q   <= wdata;
        end
    end

    always_comb begin
        glb_en     = ctrl_q[CTRL_GEN_BIT];
        pulse_mode = ctrl_q[CTRL_TYPE_BIT];
        act_high   = ctrl_q[CTRL_POL_BIT];
    end

    assert_ctrl_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q & ~CTRL_MSK) == '0));

    assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(en_q));

    assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_q));

endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         glb_en,
    input  logic         pulse_mode,
    input  logic         act_high,
    input  logic [W-1:0] masked,
    output logic         irq_out
);

    irq_state_e   state_q, state_n;
    logic [W-1:0] masked_q;
    logic         pending;
    logic         fresh;
    logic         active;

    always_comb begin
        pending = |masked;
        fresh   = |(masked & ~masked_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= IRQ_IDLE;
            masked_q <= '0;
        end else begin
            state_q  <= state_n;
            masked_q <= masked;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (glb_en && !pulse_mode && pending)     state_n = IRQ_LEVEL;
                else if (glb_en && pulse_mode && fresh)   state_n = IRQ_PULSE;
            end
            IRQ_LEVEL: begin
                if (!glb_en || pulse_mode || !pending)    state_n = IRQ_IDLE;
            end
            IRQ_PULSE: begin
                if (glb_en && pulse_mode && fresh)        state_n = IRQ_PULSE;
                else                                      state_n = IRQ_IDLE;
            end
            default:                                      state_n = IRQ_IDLE;
        endcase
    end

    always_comb begin
        active  = (state_q != IRQ_IDLE);
        irq_out = act_high ? active : ~active;
    end

    assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && !pulse_mode && pending) |=> (state_q == IRQ_LEVEL));

    assert_level_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_LEVEL && !pending) |=> (state_q == IRQ_IDLE));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PULSE && !fresh) |=> (state_q == IRQ_IDLE));

    assert_gate_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (state_q == IRQ_IDLE));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned  STAT_W    = 8,
    parameter int unsigned  ADDR_W    = 2,
    parameter logic [7:0]   STAT_RST  = 8'h10,
    parameter logic [7:0]   STAT_IMPL = 8'hDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              irq_out
);

    localparam logic [STAT_W-1:0] RST_V  = STAT_W'(STAT_RST);
    localparam logic [STAT_W-1:0] IMPL_V = STAT_W'(STAT_IMPL);

    logic              wr_ctrl, wr_en, wr_stat;
    logic [STAT_W-1:0] status_q, ctrl_q, en_q, masked;
    logic              glb_en, pulse_mode, act_high;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
        wr_en   = bus_wr && (bus_addr == ADDR_W'(ADDR_ENABLE));
        wr_stat = bus_wr && (bus_addr == ADDR_W'(ADDR_STATUS));
        masked  = status_q & en_q;
    end

    irq_status_bank #(
        .W(STAT_W), .RST_VAL(RST_V), .IMPL_MSK(IMPL_V)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .clr_we(wr_stat), .clr_data(bus_wdata), .status_q(status_q)
    );

    irq_cfg_regs #(.W(STAT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ctrl_we(wr_ctrl), .en_we(wr_en),
        .wdata(bus_wdata), .ctrl_q(ctrl_q), .en_q(en_q),
        .glb_en(glb_en), .pulse_mode(pulse_mode), .act_high(act_high)
    );

    irq_out_fsm #(.W(STAT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .pulse_mode(pulse_mode),
        .act_high(act_high), .masked(masked), .irq_out(irq_out)
    );

    always_comb begin
        if (bus_addr == ADDR_W'(ADDR_CTRL))        bus_rdata = ctrl_q;
        else if (bus_addr == ADDR_W'(ADDR_ENABLE)) bus_rdata = en_q;
        else if (bus_addr == ADDR_W'(ADDR_STATUS)) bus_rdata = status_q;
        else                                       bus_rdata = '0;
    end

endmodule

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_in = '0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic fire(input logic [7:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd2, v); check("R1 status reset", v, 8'h10);
        rd(2'd0, v); check("R1 ctrl reset", v, 8'h00);
        rd(2'd1, v); check("R1 enable reset", v, 8'h00);
        check("R1 irq idle high", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_latch;
        logic [7:0] v;
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R3 clear all", v, 8'h00);
        fire(8'h01);
        rd(2'd2, v); check("R2 touch bit without enable", v, 8'h01);
        fire(8'hFF);
        rd(2'd2, v); check("R2 all events, reserved bit5 stays 0", v, 8'hDF);
        idle(2);
        check("R2 no irq with gate off", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_w1c;
        logic [7:0] v;
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R3 zero write no effect", v, 8'hDF);
        wr(2'd2, 8'h0F);
        rd(2'd2, v); check("R3 partial clear", v, 8'hD0);
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R3 full clear", v, 8'h00);
    endtask

    task automatic t_evt_wins;
        logic [7:0] v;
        fire(8'h01);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h41; evt_in = 8'h40;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0; evt_in = '0;
        rd(2'd2, v); check("R4 event beats clear", v, 8'h40);
        wr(2'd2, 8'hFF);
    endtask

    task automatic t_map;
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        rd(2'd0, v); check("R5 ctrl upper bits zero", v, 8'h07);
        wr(2'd1, 8'hA5);
        rd(2'd1, v); check("R11 enable at address 1", v, 8'hA5);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); check("R11 address 3 reads zero", v, 8'h00);
        rd(2'd0, v); check("R11 ctrl untouched by address 3", v, 8'h07);
        rd(2'd1, v); check("R11 enable untouched by address 3", v, 8'hA5);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hFF);
    endtask

    task automatic t_level;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h05);
        check("R9 active-high idle low", {7'd0, irq_out}, 8'h00);
        fire(8'h02);
        idle(2);
        check("R6 unenabled bit no irq", {7'd0, irq_out}, 8'h00);
        fire(8'h01);
        check("R6 not yet active after one edge", {7'd0, irq_out}, 8'h00);
        @(negedge clk);
        check("R6 active two edges after event", {7'd0, irq_out}, 8'h01);
        idle(3);
        check("R7 level held", {7'd0, irq_out}, 8'h01);
        wr(2'd2, 8'h02);
        idle(2);
        check("R7 clearing unenabled bit keeps level", {7'd0, irq_out}, 8'h01);
        wr(2'd2, 8'h01);
        check("R7 still active right after clear", {7'd0, irq_out}, 8'h01);
        @(negedge clk);
        check("R7 released after clear", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_pulse;
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h07);
        idle(2);
        check("R8 idle before event", {7'd0, irq_out}, 8'h00);
        fire(8'h80);
        check("R8 not yet", {7'd0, irq_out}, 8'h00);
        @(negedge clk);
        check("R8 pulse high", {7'd0, irq_out}, 8'h01);
        @(negedge clk);
        check("R8 pulse one cycle", {7'd0, irq_out}, 8'h00);
        fire(8'h80);
        @(negedge clk);
        check("R8 repeat while set no pulse", {7'd0, irq_out}, 8'h00);
        wr(2'd2, 8'h80);
        fire(8'h80);
        @(negedge clk);
        check("R8 second pulse after clear", {7'd0, irq_out}, 8'h01);
        @(negedge clk);
        check("R8 second pulse ends", {7'd0, irq_out}, 8'h00);
        wr(2'd2, 8'hFF);
    endtask

    task automatic t_pol;
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        check("R9 active-low idle high", {7'd0, irq_out}, 8'h01);
        fire(8'h01);
        @(negedge clk);
        check("R9 active-low asserted", {7'd0, irq_out}, 8'h00);
        wr(2'd0, 8'h05);
        check("R9 flip to active-high", {7'd0, irq_out}, 8'h01);
    endtask

    task automatic t_gate;
        wr(2'd0, 8'h04);
        @(negedge clk);
        check("R10 gate off inactive", {7'd0, irq_out}, 8'h00);
        idle(3);
        check("R10 stays inactive", {7'd0, irq_out}, 8'h00);
        wr(2'd0, 8'h05);
        @(negedge clk);
        check("R10 gate on asserts", {7'd0, irq_out}, 8'h01);
        wr(2'd0, 8'h04);
        @(negedge clk);
        check("R10 gate off releases", {7'd0, irq_out}, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_w1c();
        t_evt_wins();
        t_map();
        t_level();
        t_pulse();
        t_pol();
        t_gate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x00 expected=0x01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule